// File: doc/BRIEF.md
# Gray-Scale PWM Engine with Prescaler

This block turns a set of 8-bit gray-scale values, one per LED channel, into per-channel on/off enables for a constant-current driver stage. A gray-scale clock (`gs_clk`) arrives as a slow input and is sampled on the fast system clock. Once the blanking input is released, the block waits for a rising edge of `gs_clk`. On the falling edge that follows, it switches on every channel with a nonzero value. From then on, an 8-bit step counter advances once every N falling edges of `gs_clk`. Each channel goes dark when the counter reaches that channel's value.

The divisor N comes from the upper three bits of a brightness byte. It applies only while brightness control is enabled. The lower five bits of the same byte are passed on as a current-trim code for the current DAC. When brightness control is disabled, the trim code is full scale. The block can pair its outputs so that eight gray-scale bytes drive sixteen tied outputs. It also forwards delayed copies of the gray-scale clock and of the blank input, so that a following stage can be chained with staggered switching. A run-status flag, `pwm_active`, tells the data loader when the outputs are live, so the loader can hold off brightness rewrites.

Top module: `gs_pwm_engine`

## Requirements
- R1: After reset, `ch_on` is all zero, `pwm_active` is 0 and `trim` is 5'b11111. While `blank` is high, `ch_on` is all zero and `pwm_active` is 0.
- R2: After `blank` falls, no output turns on until `gs_clk` has made a low-to-high transition and then a high-to-low one. A falling edge that has no rising edge before it (after the release) does not start a cycle. At the starting fall, exactly the channels with a nonzero value turn on.
- R3: Count falling edges of `gs_clk` after the starting fall as k, and let N be the divisor. Channel i is on while floor(k/N) is below its 8-bit value, where bit 0 is the LSB of the byte at `gs_data[8*i +: 8]`. A value of 0 never turns on.
- R4: With `bc_en` high, `bright[7:5]` = n gives N = n+1, so 3'b000 gives 1 and 3'b111 gives 8. With `bc_en` low, N = 1.
- R5: The divisor is captured at the starting fall. Changing `bright` while the cycle is running does not alter the remaining on-times.
- R6: Once floor(k/N) reaches 255, all outputs stay off and `pwm_active` stays 0 until `blank` is pulsed.
- R7: With `mode16` low, outputs 2j and 2j+1 both follow byte j, for j from 0 to NCH/2-1. The bytes at index NCH/2 and above have no effect.
- R8: `trim` equals `bright[4:0]` when `bc_en` is high and 5'b11111 when `bc_en` is low, one clock after the inputs change.
- R9: `gs_clk_dly` and `blank_dly` equal `gs_clk` and `blank` as they were DLY clock edges earlier.
- R10: `pwm_active` is 1 from the starting fall until the count reaches 255 or `blank` rises. No output is on while it is 0.
- R11: Raising `blank` in the middle of a cycle switches all outputs off. A new cycle after that again needs a release, a rising edge and a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gs_clk | input | 1 | Gray-scale clock, sampled on `clk` |
| blank | input | 1 | Forces all outputs off and restarts the cycle |
| mode16 | input | 1 | 1: one byte per output; 0: one byte per output pair |
| bc_en | input | 1 | Enables the divisor and the trim bits of `bright` |
| bright | input | 8 | [7:5] divisor code, [4:0] current trim |
| gs_data | input | NCH*8 | Gray-scale value of channel i at [8*i +: 8] |
| ch_on | output | NCH | Per-channel current enable |
| trim | output | 5 | Current-trim code for the DAC |
| pwm_active | output | 1 | A gray-scale cycle is running |
| gs_clk_dly | output | 1 | `gs_clk` delayed by DLY clocks |
| blank_dly | output | 1 | `blank` delayed by DLY clocks |

## Verification
A channel's turn-off can fall in the same cycle as the counter reaching its end state. A channel holding 255 goes dark exactly when the whole engine stops. Every sweep therefore places 255 on one channel and 0 on another. At the final falling edge for each divisor, the bench compares the channel outputs and `pwm_active` against the arithmetic model together, so a one-edge slip in either one shows up. In a second collision, the divisor is rewritten while the counter is mid-run. The bench judges the remaining on-times against the divisor captured at the starting fall, not the new one.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
    localparam int GS_BITS   = 8;
    localparam int PS_BITS   = 3;
    localparam int TRIM_BITS = 5;
    localparam int BR_BITS   = PS_BITS + TRIM_BITS;
    localparam logic [GS_BITS-1:0] GS_MAX = {GS_BITS{1'b1}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAITF,
        ST_RUN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e         st;
        logic [GS_BITS-1:0] cnt;
        logic [PS_BITS-1:0] pcnt;
        logic [PS_BITS-1:0] code;
    } seq_regs_t;
endpackage

// File: rtl/gsp_edge_sync.sv
module gsp_edge_sync #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gs_clk,
    input  logic blank,
    output logic gs_rise,
    output logic gs_fall,
    output logic blank_s,
    output logic gs_dly,
    output logic blank_dly
);
    typedef struct packed {
        logic           gs_s;
        logic           gs_p;
        logic           blk_s;
        logic [DLY-1:0] gsd;
        logic [DLY-1:0] bkd;
    } es_regs_t;

    es_regs_t q, d;

    always_comb begin
        d        = q;
        d.gs_s   = gs_clk;
        d.gs_p   = q.gs_s;
        d.blk_s  = blank;
        d.gsd[0] = gs_clk;
        d.bkd[0] = blank;
        for (int j = 1; j < DLY; j++) begin
            d.gsd[j] = q.gsd[j-1];
            d.bkd[j] = q.bkd[j-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.blk_s <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign gs_rise   = q.gs_s & ~q.gs_p;
    assign gs_fall   = ~q.gs_s & q.gs_p;
    assign blank_s   = q.blk_s;
    assign gs_dly    = q.gsd[DLY-1];
    assign blank_dly = q.bkd[DLY-1];
endmodule

// File: rtl/gsp_sequencer.sv
module gsp_sequencer
    import gsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blank_s,
    input  logic               gs_rise,
    input  logic               gs_fall,
    input  logic [PS_BITS-1:0] code_in,
    output logic               run_nx,
    output logic [GS_BITS-1:0] cnt_nx,
    output logic               active
);
    seq_regs_t q, d;

    always_comb begin
        d = q;
        if (blank_s) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.pcnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE:  d.st = gs_rise ? ST_WAITF : ST_ARM;
                ST_ARM:   if (gs_rise) d.st = ST_WAITF;
                ST_WAITF: if (gs_fall) begin
                    d.st   = ST_RUN;
                    d.cnt  = '0;
                    d.pcnt = '0;
                    d.code = code_in;
                end
                ST_RUN:   if (gs_fall) begin
                    if (q.pcnt == q.code) begin
                        d.pcnt = '0;
                        d.cnt  = q.cnt + 1'b1;
                        if (q.cnt == GS_MAX - 1'b1) d.st = ST_DONE;
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
                ST_DONE:  d.st = ST_DONE;
                default:  d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign run_nx = (d.st == ST_RUN);
    assign cnt_nx = d.cnt;
    assign active = (q.st == ST_RUN);

    seq_state_e         st_q;
    logic [GS_BITS-1:0] cnt_q;
    logic [PS_BITS-1:0] pcnt_q;
    logic [PS_BITS-1:0] code_q;
    assign st_q   = q.st;
    assign cnt_q  = q.cnt;
    assign pcnt_q = q.pcnt;
    assign code_q = q.code;

    p_blank_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        blank_s |=> (st_q == ST_IDLE));
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && $past(st_q) == ST_RUN) |->
        (cnt_q == $past(cnt_q) || cnt_q == GS_BITS'($past(cnt_q) + 1'b1)));
    p_prescale_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (pcnt_q <= code_q));
    p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> $stable(code_q));
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |=> (st_q == ST_DONE || st_q == ST_IDLE));
    p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |-> (cnt_q == GS_MAX));
endmodule

// File: rtl/gsp_channels.sv
module gsp_channels
    import gsp_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode16,
    input  logic [NCH*GS_BITS-1:0] gs_data,
    input  logic                   run_nx,
    input  logic [GS_BITS-1:0]     cnt_nx,
    output logic [NCH-1:0]         ch_on
);
    localparam int NPAIR = NCH / 2;

    typedef struct packed {
        logic [NCH-1:0] on;
        logic           wide;
    } ch_regs_t;

    ch_regs_t q, d;

    always_comb begin
        d      = q;
        d.wide = mode16;
        for (int i = 0; i < NCH; i++) begin
            int                 idx;
            logic [GS_BITS-1:0] val;
            idx     = mode16 ? i : (i >> 1);
            val     = gs_data[idx*GS_BITS +: GS_BITS];
            d.on[i] = run_nx && (cnt_nx < val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.on   <= '0;
            q.wide <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ch_on = q.on;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        p_pair_tied_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !q.wide |-> (q.on[2*k] == q.on[2*k+1]));
    end
endmodule

// File: rtl/gs_pwm_engine.sv
module gs_pwm_engine
    import gsp_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DLY = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gs_clk,
    input  logic                   blank,
    input  logic                   mode16,
    input  logic                   bc_en,
    input  logic [BR_BITS-1:0]     bright,
    input  logic [NCH*GS_BITS-1:0] gs_data,
    output logic [NCH-1:0]         ch_on,
    output logic [TRIM_BITS-1:0]   trim,
    output logic                   pwm_active,
    output logic                   gs_clk_dly,
    output logic                   blank_dly
);
    logic               gs_rise, gs_fall, blank_s;
    logic               run_nx;
    logic [GS_BITS-1:0] cnt_nx;
    logic [PS_BITS-1:0] code_in;
    logic [TRIM_BITS-1:0] trim_d, trim_q;

    gsp_edge_sync #(.DLY(DLY)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .gs_clk   (gs_clk),
        .blank    (blank),
        .gs_rise  (gs_rise),
        .gs_fall  (gs_fall),
        .blank_s  (blank_s),
        .gs_dly   (gs_clk_dly),
        .blank_dly(blank_dly)
    );

    always_comb begin
        code_in = bc_en ? bright[BR_BITS-1 -: PS_BITS] : '0;
        trim_d  = bc_en ? bright[TRIM_BITS-1:0] : {TRIM_BITS{1'b1}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trim_q <= {TRIM_BITS{1'b1}};
        else        trim_q <= trim_d;
    end

    assign trim = trim_q;

    gsp_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .blank_s(blank_s),
        .gs_rise(gs_rise),
        .gs_fall(gs_fall),
        .code_in(code_in),
        .run_nx (run_nx),
        .cnt_nx (cnt_nx),
        .active (pwm_active)
    );

    gsp_channels #(.NCH(NCH)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode16 (mode16),
        .gs_data(gs_data),
        .run_nx (run_nx),
        .cnt_nx (cnt_nx),
        .ch_on  (ch_on)
    );

    p_on_needs_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_on != '0) |-> pwm_active);
    p_trim_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bc_en) |-> (trim == {TRIM_BITS{1'b1}}));
endmodule

// File: tb/sim_gs_pwm_engine.sv
module sim_gs_pwm_engine;
    localparam int NCH = 16;
    localparam int DLY = 2;
    localparam int H   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gs_clk = 1'b0;
    logic             blank = 1'b1;
    logic             mode16 = 1'b1;
    logic             bc_en = 1'b0;
    logic [7:0]       bright = 8'h1F;
    logic [NCH*8-1:0] gs_data = '0;
    logic [NCH-1:0]   ch_on;
    logic [4:0]       trim;
    logic             pwm_active, gs_clk_dly, blank_dly;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    logic [7:0] vals [NCH];
    logic [DLY-1:0] hg = '0, hb = '0;

    always #4 clk = ~clk;

    gs_pwm_engine #(.NCH(NCH), .DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .gs_clk(gs_clk), .blank(blank),
        .mode16(mode16), .bc_en(bc_en), .bright(bright), .gs_data(gs_data),
        .ch_on(ch_on), .trim(trim), .pwm_active(pwm_active),
        .gs_clk_dly(gs_clk_dly), .blank_dly(blank_dly)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] expect_on(input int k, input int n, input bit m16);
        logic [NCH-1:0] e;
        for (int i = 0; i < NCH; i++) begin
            int b;
            b = m16 ? i : i / 2;
            e[i] = ((k / n) < int'(vals[b]));
        end
        return e;
    endfunction

    // R9: delayed copies against a bench history of the inputs
    always @(posedge clk) begin
        hg <= {hg[DLY-2:0], gs_clk};
        hb <= {hb[DLY-2:0], blank};
    end
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cyc > DLY + 4 && !finished) begin
            chk("R9 gs_clk_dly", 32'(gs_clk_dly), 32'(hg[DLY-1]));
            chk("R9 blank_dly", 32'(blank_dly), 32'(hb[DLY-1]));
        end
        if (cyc > 190000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_cycle(input int run, input int code, input bit bce,
                             input bit m16, input bit start_high, input int abort_at);
        int n;
        logic [NCH-1:0] e;
        n = bce ? code + 1 : 1;
        for (int i = 0; i < NCH; i++) begin
            int v;
            v = (i * 17 + run * 29) % 256;
            if (i == run % NCH) v = 0;
            if (i == (run + 5) % NCH) v = 255;
            vals[i] = 8'(v);
        end
        @(negedge clk);
        blank = 1'b1;
        gs_clk = start_high;
        bc_en = bce;
        mode16 = m16;
        bright = {3'(code), 5'(run * 3)};
        for (int i = 0; i < NCH; i++) gs_data[i*8 +: 8] = vals[i];
        wait_n(6);
        chk("R1 blank off", 32'(ch_on), 0);
        chk("R1 blank inactive", 32'(pwm_active), 0);
        chk("R8 trim", 32'(trim), bce ? 32'(bright[4:0]) : 32'h1F);
        blank = 1'b0;
        wait_n(6);
        chk("R2 released, no edge", 32'(ch_on), 0);
        if (start_high) begin
            gs_clk = 1'b0;
            wait_n(2 * H);
            chk("R2 fall without rise", 32'(ch_on), 0);
        end
        gs_clk = 1'b1;
        wait_n(H);
        chk("R2 rise only", 32'(ch_on), 0);
        gs_clk = 1'b0;
        wait_n(H);
        chk("R2 start nonzero only", 32'(ch_on), 32'(expect_on(0, n, m16)));
        chk("R10 active at start", 32'(pwm_active), 1);
        bright = {3'(code + 3), 5'(run * 7 + 1)};
        for (int i = 0; i < NCH; i++) gs_data[i*8 +: 8] = m16 ? vals[i] : (i >= NCH / 2 ? ~vals[i] : vals[i]);
        wait_n(2);
        chk("R8 trim tracks", 32'(trim), bce ? 32'(bright[4:0]) : 32'h1F);
        for (int k = 1; k <= 255 * n + 2; k++) begin
            gs_clk = 1'b1;
            wait_n(H);
            gs_clk = 1'b0;
            wait_n(H);
            e = expect_on(k, n, m16);
            chk(m16 ? "R3 R4 R5 on-time" : "R7 paired on-time", 32'(ch_on), 32'(e));
            chk("R10 R6 active", 32'(pwm_active), 32'((k / n) < 255));
            if (abort_at > 0 && k == abort_at) begin
                blank = 1'b1;
                wait_n(3);
                chk("R11 abort off", 32'(ch_on), 0);
                chk("R11 abort inactive", 32'(pwm_active), 0);
                return;
            end
        end
        wait_n(20);
        chk("R6 stays off", 32'(ch_on), 0);
    endtask

    initial begin
        wait_n(1);
        chk("R1 reset ch_on", 32'(ch_on), 0);
        chk("R1 reset active", 32'(pwm_active), 0);
        chk("R1 reset trim", 32'(trim), 32'h1F);
        wait_n(3);
        rst_n = 1'b1;
        wait_n(4);
        for (int r = 0; r < 8; r++) run_cycle(r, r, 1'b1, r[0], r[1], 0);
        run_cycle(8, 7, 1'b0, 1'b1, 1'b0, 0);
        run_cycle(9, 2, 1'b1, 1'b1, 1'b1, 100);
        run_cycle(10, 0, 1'b1, 1'b1, 1'b0, 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule